// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer, nine bits wide by default, that carries words from one clock domain into another. The writer and the reader each have their own clock and a pair of active-low enables. An access takes place only when both enables of its side agree. Four active-low status flags report the fill level: full and almost-full are produced in the write domain, and empty and almost-empty are produced in the read domain. The two almost thresholds are set by offsets that an external offset loader supplies as inputs. The almost-full offset counts down from the top of the buffer, and the almost-empty offset counts up from zero.

The second write enable has two possible roles, and the block picks one while reset is held. If the pin is high during reset, it becomes an ordinary second write enable. If it is low during reset, it becomes a load strobe for the offset loader. In that role, driving it low blocks data writes into the buffer and raises `ofs_load` whenever the first write enable is also low.

Pointers cross between the domains as Gray code through two-flop synchronisers, so a flag clears a few cycles of the opposite clock after the event that clears it. Read data is registered. An output-enable input forces the data output to zero. The depth must be a power of two.

Top module: `dcf_pflag_fifo`

## Requirements
- R1: With `rst_n` low, and after it is released, the flags read `full_n`=1, `paf_n`=1, `pae_n`=0 and `empty_n`=0, and `dout` reads 0 while `oe_n` is 0.
- R2: Words leave in the order they were accepted. A read accepted on a rising `rclk` edge shows its word on `dout` after that same edge. Each write and read pointer changes by at most one bit per edge of its own clock.
- R3: `full_n` is low on `wclk` whenever the buffer holds DEPTH words. Write attempts made while it is low are ignored.
- R4: `empty_n` is low on `rclk` whenever the buffer holds no words. Read attempts made while it is low are ignored, and `dout` keeps its value.
- R5: Once settled, `paf_n` is low exactly when the word count is at least DEPTH − `full_ofs`, and it changes on `wclk`. It is always low while `full_n` is low.
- R6: Once settled, `pae_n` is low exactly when the word count is at most `empty_ofs`, and it changes on `rclk`. It is always low while `empty_n` is low.
- R7: If `we2_n` is high during reset, a write requires `we1_n`=0 and `we2_n`=0, and `ofs_load` stays 0. If `we2_n` is low during reset, a write requires `we1_n`=0 and `we2_n`=1. In that role, `we2_n`=0 blocks writes, and `ofs_load` is 1 whenever both `we1_n` and `we2_n` are 0.
- R8: A read takes place only when both `re1_n` and `re2_n` are 0. With only one of them low, no word is consumed.
- R9: While `oe_n` is 1, `dout` is 0. When `oe_n` returns to 0, `dout` again shows the last word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain in step with its clock |
| we1_n | input | 1 | First write enable, active low |
| we2_n | input | 1 | Second write enable or offset-load strobe, role fixed during reset |
| din | input | DW | Write data |
| re1_n | input | 1 | First read enable, active low |
| re2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low; when high, dout is forced to 0 |
| full_ofs | input | AW+1 | Almost-full offset m |
| empty_ofs | input | AW+1 | Almost-empty offset n |
| dout | output | DW | Registered read data |
| full_n | output | 1 | Full flag, active low, write domain |
| paf_n | output | 1 | Almost-full flag, active low, write domain |
| pae_n | output | 1 | Almost-empty flag, active low, read domain |
| empty_n | output | 1 | Empty flag, active low, read domain |
| ofs_load | output | 1 | High while the load strobe and the first write enable are both active |

## Verification
The bench fills the buffer to exactly DEPTH words and then keeps writing. A design whose full check is off by one would either refuse the last word or overwrite the oldest one, and the drained data sequence shows either error. Each almost flag is checked one word below and one word at its threshold, with the default offsets of 7 and with other offsets. A design that used a strict comparison where an inclusive one is needed would move its flag by one word. The bench also reads an empty buffer, reads with only one read enable low, and writes with the enables in the wrong combination for the selected role. A design that advanced a pointer in any of these cases would later deliver a stale or skipped word. Finally, writer and reader run together on clocks of different periods, so a design whose pointer crossing miscounted would corrupt the streamed sequence.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Role of the second write-enable pin, latched while reset is held
  typedef enum logic {
    WE2_AS_ENABLE = 1'b0,
    WE2_AS_LOAD   = 1'b1
  } we2_role_e;

endpackage

// File: rtl/dcf_cdc_sync.sv
module dcf_cdc_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DW    = 9,
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic          wclk,
  input  logic          wen,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          ren,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (wen) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rdata <= '0;
    end else if (ren) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we1_n,
  input  logic          we2_n,
  input  logic [PW-1:0] m_ofs,
  input  logic [PW-1:0] rgray_s,
  output logic [PW-1:0] wgray,
  output logic [AW-1:0] waddr,
  output logic          wen,
  output logic          full_n,
  output logic          paf_n,
  output logic          ofs_load,
  output we2_role_e     role,
  output logic          wrst_n
);

  localparam logic [PW:0] DEPTH_X = (PW+1)'(DEPTH);

  logic [1:0]    rsync_q;
  logic [PW-1:0] wbin, wbin_nx, rbin, cnt_nx;
  logic          wr_req, full_nx, paf_nx;

  // Reset: asserted at once, released after two write clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign wrst_n = rsync_q[1];

  // Pin role captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      role <= we2_n ? WE2_AS_ENABLE : WE2_AS_LOAD;
    end
  end

  // Gray to binary of the synchronised read pointer
  for (genvar gi = 0; gi < PW; gi++) begin : g_g2b
    assign rbin[gi] = ^(rgray_s >> gi);
  end

  always_comb begin
    if (role == WE2_AS_ENABLE) begin
      wr_req = !we1_n && !we2_n;
    end else begin
      wr_req = !we1_n && we2_n;
    end
    wen      = wr_req && full_n && wrst_n;
    wbin_nx  = wbin + {{(PW-1){1'b0}}, wen};
    cnt_nx   = wbin_nx - rbin;
    full_nx  = ({1'b0, cnt_nx} != DEPTH_X);
    paf_nx   = (({1'b0, cnt_nx} + {1'b0, m_ofs}) < DEPTH_X);
    ofs_load = (role == WE2_AS_LOAD) && !we1_n && !we2_n && wrst_n;
  end

  always_ff @(posedge clk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      full_n <= 1'b1;
      paf_n  <= 1'b1;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= wbin_nx ^ (wbin_nx >> 1);
      full_n <= full_nx;
      paf_n  <= paf_nx;
    end
  end

  assign waddr = wbin[AW-1:0];

endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          re1_n,
  input  logic          re2_n,
  input  logic [PW-1:0] n_ofs,
  input  logic [PW-1:0] wgray_s,
  output logic [PW-1:0] rgray,
  output logic [AW-1:0] raddr,
  output logic          ren,
  output logic          empty_n,
  output logic          pae_n,
  output logic          rrst_n
);

  logic [1:0]    rsync_q;
  logic [PW-1:0] rbin, rbin_nx, wbin, cnt_nx;
  logic          empty_nx, pae_nx;

  // Reset: asserted at once, released after two read clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rrst_n = rsync_q[1];

  for (genvar gi = 0; gi < PW; gi++) begin : g_g2b
    assign wbin[gi] = ^(wgray_s >> gi);
  end

  always_comb begin
    ren      = !re1_n && !re2_n && empty_n && rrst_n;
    rbin_nx  = rbin + {{(PW-1){1'b0}}, ren};
    cnt_nx   = wbin - rbin_nx;
    empty_nx = (cnt_nx != '0);
    pae_nx   = (cnt_nx > n_ofs);
  end

  always_ff @(posedge clk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      empty_n <= 1'b0;
      pae_n   <= 1'b0;
    end else begin
      rbin    <= rbin_nx;
      rgray   <= rbin_nx ^ (rbin_nx >> 1);
      empty_n <= empty_nx;
      pae_n   <= pae_nx;
    end
  end

  assign raddr = rbin[AW-1:0];

  // Keep the depth parameter meaningful for the address slice
  if ((1 << AW) != DEPTH) begin : g_bad_depth
    initial $display("dcf_rd_ctl: DEPTH must be a power of two");
  end

endmodule

// File: rtl/dcf_pflag_fifo.sv
module dcf_pflag_fifo
  import dcf_pkg::*;
#(
  parameter int DW    = 9,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          we1_n,
  input  logic          we2_n,
  input  logic [DW-1:0] din,
  input  logic          re1_n,
  input  logic          re2_n,
  input  logic          oe_n,
  input  logic [PW-1:0] full_ofs,
  input  logic [PW-1:0] empty_ofs,
  output logic [DW-1:0] dout,
  output logic          full_n,
  output logic          empty_n,
  output logic          paf_n,
  output logic          pae_n,
  output logic          ofs_load
);

  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          wen, ren, wrst_n, rrst_n;
  logic [DW-1:0] rdata;
  we2_role_e     role;

  dcf_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .clk(wclk), .rst_n(rst_n), .we1_n(we1_n), .we2_n(we2_n),
    .m_ofs(full_ofs), .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr),
    .wen(wen), .full_n(full_n), .paf_n(paf_n), .ofs_load(ofs_load),
    .role(role), .wrst_n(wrst_n)
  );

  dcf_rd_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
    .clk(rclk), .rst_n(rst_n), .re1_n(re1_n), .re2_n(re2_n),
    .n_ofs(empty_ofs), .wgray_s(wgray_s), .rgray(rgray), .raddr(raddr),
    .ren(ren), .empty_n(empty_n), .pae_n(pae_n), .rrst_n(rrst_n)
  );

  dcf_cdc_sync #(.W(PW)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s)
  );

  dcf_cdc_sync #(.W(PW)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s)
  );

  dcf_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .wclk(wclk), .wen(wen), .waddr(waddr), .wdata(din),
    .rclk(rclk), .rrst_n(rrst_n), .ren(ren), .raddr(raddr), .rdata(rdata)
  );

  assign dout = oe_n ? '0 : rdata;

endmodule

// File: rtl/dcf_pflag_fifo_chk.sv
module dcf_pflag_fifo_chk
  import dcf_pkg::*;
#(
  parameter int PW = 11
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          full_n,
  input logic          paf_n,
  input logic          empty_n,
  input logic          pae_n,
  input logic          we2_n,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray,
  input we2_role_e     role
);

  // R3
  full_blocks_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(wgray));

  // R4
  empty_blocks_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(rgray));

  // R5
  paf_under_full_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> !paf_n);

  // R6
  pae_under_empty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !pae_n);

  // R7
  strobe_blocks_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (role == WE2_AS_LOAD && !we2_n) |=> $stable(wgray));

  // R2
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R2
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

endmodule

bind dcf_pflag_fifo dcf_pflag_fifo_chk #(.PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .full_n(full_n), .paf_n(paf_n),
  .empty_n(empty_n), .pae_n(pae_n), .we2_n(we2_n), .wgray(wgray),
  .rgray(rgray), .role(role)
);

// File: tb/dcf_pflag_fifo_tb.sv
`timescale 1ns/1ps
module dcf_pflag_fifo_tb;

  localparam int DW = 9;
  localparam int D  = 32;
  localparam int PW = $clog2(D) + 1;

  logic wclk = 1'b0, rclk = 1'b0;
  logic rst_n, we1_n, we2_n, re1_n, re2_n, oe_n;
  logic [DW-1:0] din, dout;
  logic [PW-1:0] full_ofs, empty_ofs;
  logic full_n, empty_n, paf_n, pae_n, ofs_load;

  int checks = 0, errors = 0;
  bit load_role = 1'b0;
  logic [DW-1:0] mq[$];
  logic [DW-1:0] last_rd = '0;

  always #4 wclk = ~wclk;   // 125 MHz write clock
  always #5 rclk = ~rclk;   // unrelated read clock

  dcf_pflag_fifo #(.DW(DW), .DEPTH(D)) u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .we1_n(we1_n), .we2_n(we2_n),
    .din(din), .re1_n(re1_n), .re2_n(re2_n), .oe_n(oe_n),
    .full_ofs(full_ofs), .empty_ofs(empty_ofs), .dout(dout),
    .full_n(full_n), .empty_n(empty_n), .paf_n(paf_n), .pae_n(pae_n),
    .ofs_load(ofs_load)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (8) @(negedge wclk);
    @(negedge rclk);
  endtask

  task automatic flags_chk(input string req);
    int cnt;
    cnt = mq.size();
    chk(full_n  == (cnt != D), req, "full_n",  full_n,  cnt != D);
    chk(paf_n   == (cnt < D - int'(full_ofs)), req, "paf_n", paf_n, cnt < D - int'(full_ofs));
    chk(pae_n   == (cnt > int'(empty_ofs)), req, "pae_n", pae_n, cnt > int'(empty_ofs));
    chk(empty_n == (cnt != 0), req, "empty_n", empty_n, cnt != 0);
  endtask

  task automatic do_reset(input logic we2_level);
    rst_n = 1'b0; we1_n = 1'b1; we2_n = we2_level;
    re1_n = 1'b1; re2_n = 1'b1;
    repeat (4) @(negedge wclk);
    rst_n = 1'b1; we2_n = 1'b1;
    load_role = !we2_level;
    mq.delete();
    last_rd = '0;
    repeat (4) @(negedge rclk);
    repeat (4) @(negedge wclk);
  endtask

  task automatic wr(input logic [DW-1:0] d, input logic e1, input logic e2);
    logic acc;
    @(negedge wclk);
    din = d; we1_n = e1; we2_n = e2;
    #1;
    acc = !e1 && (load_role ? e2 : !e2) && full_n;
    if (acc) mq.push_back(d);
    @(posedge wclk);
    #1;
    we1_n = 1'b1; we2_n = 1'b1;
  endtask

  task automatic rd(input logic e1, input logic e2, input string req);
    logic acc;
    logic [DW-1:0] exp, prev;
    @(negedge rclk);
    re1_n = e1; re2_n = e2; prev = dout;
    #1;
    acc = !e1 && !e2 && empty_n;
    exp = '0;
    if (acc) exp = mq.pop_front();
    @(posedge rclk);
    #1;
    re1_n = 1'b1; re2_n = 1'b1;
    if (acc) begin
      chk(dout == exp, req, "read data", dout, exp);
      last_rd = exp;
    end else begin
      chk(dout == prev, req, "dout held on ignored read", dout, prev);
    end
  endtask

  task automatic drain(input string req);
    while (mq.size() > 0) rd(1'b0, 1'b0, req);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    oe_n = 1'b0; din = '0; full_ofs = 7; empty_ofs = 7;
    rst_n = 1'b0; we1_n = 1'b1; we2_n = 1'b1; re1_n = 1'b1; re2_n = 1'b1;
    #1;
    // R1 flags while reset is held, then after release
    @(negedge wclk);
    flags_chk("R1");
    do_reset(1'b1);
    flags_chk("R1");
    chk(dout == '0, "R1", "dout after reset", dout, 0);

    // R6 almost-empty around n = 7
    for (int i = 0; i < 7; i++) wr(DW'(i + 16), 1'b0, 1'b0);
    settle(); flags_chk("R6");
    wr(9'h0A5, 1'b0, 1'b0);
    settle(); flags_chk("R6");
    drain("R2");
    settle(); flags_chk("R4");

    // R4 read of an empty buffer
    rd(1'b0, 1'b0, "R4");

    // R8 one read enable alone consumes nothing
    wr(9'h133, 1'b0, 1'b0);
    settle();
    rd(1'b0, 1'b1, "R8");
    rd(1'b1, 1'b0, "R8");
    settle(); flags_chk("R8");
    rd(1'b0, 1'b0, "R8");

    // R7 normal role: we2_n high blocks, no load strobe
    wr(9'h0FF, 1'b0, 1'b1);
    settle(); flags_chk("R7");
    @(negedge wclk); we1_n = 1'b0; we2_n = 1'b0; #1;
    chk(ofs_load == 1'b0, "R7", "ofs_load in enable role", ofs_load, 0);
    @(negedge wclk); we1_n = 1'b1; we2_n = 1'b1;
    mq.push_back(din);
    settle(); flags_chk("R7");
    drain("R7");

    // R5 / R3 almost-full and full with m = 7
    for (int i = 0; i < D - 8; i++) wr(DW'(i * 7 + 3), 1'b0, 1'b0);
    settle(); flags_chk("R5");
    wr(9'h1C0, 1'b0, 1'b0);
    settle(); flags_chk("R5");
    while (mq.size() < D) wr(DW'(mq.size() + 200), 1'b0, 1'b0);
    settle(); flags_chk("R3");
    wr(9'h111, 1'b0, 1'b0);
    wr(9'h122, 1'b0, 1'b0);
    settle(); flags_chk("R3");
    drain("R3");
    settle(); flags_chk("R4");

    // R5 / R6 with other offsets
    full_ofs = 3; empty_ofs = 5;
    for (int i = 0; i < 5; i++) wr(DW'(i + 50), 1'b0, 1'b0);
    settle(); flags_chk("R6");
    wr(9'h066, 1'b0, 1'b0);
    settle(); flags_chk("R6");
    while (mq.size() < D - 4) wr(DW'(mq.size() + 300), 1'b0, 1'b0);
    settle(); flags_chk("R5");
    wr(9'h1EE, 1'b0, 1'b0);
    settle(); flags_chk("R5");
    drain("R2");

    // R9 output enable
    oe_n = 1'b1; #1;
    chk(dout == '0, "R9", "dout with oe_n high", dout, 0);
    oe_n = 1'b0; #1;
    chk(dout == last_rd, "R9", "dout restored", dout, last_rd);

    // R2 concurrent streaming
    full_ofs = 7; empty_ofs = 7;
    fork
      begin
        for (int i = 0; i < 60; i++) wr(DW'((i * 37) ^ 9'h0AA), 1'b0, 1'b0);
      end
      begin
        for (int i = 0; i < 90; i++) rd(1'b0, 1'b0, "R2");
      end
    join
    settle();
    drain("R2");
    settle(); flags_chk("R4");

    // R7 load-strobe role
    do_reset(1'b0);
    flags_chk("R1");
    chk(dout == '0, "R1", "dout after second reset", dout, 0);
    @(negedge wclk); we1_n = 1'b0; we2_n = 1'b0; din = 9'h07E; #1;
    chk(ofs_load == 1'b1, "R7", "ofs_load in load role", ofs_load, 1);
    @(negedge wclk); we1_n = 1'b1; we2_n = 1'b1;
    wr(9'h155, 1'b0, 1'b1);
    wr(9'h0AB, 1'b0, 1'b0);
    settle(); flags_chk("R7");
    drain("R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule